// File: doc/BRIEF.md
# Static RAM with Whole-Array Wipe

This block is a synchronous behavioural model of a small static RAM of 16,384 bits. The bits are organised as 4,096 words of 4 bits. Every control input is active low and sampled on the rising clock edge. A select input enables the part. With select low, a write strobe picks between a read and a write. A third input, the wipe input, zeroes the entire array in one operation. A wipe is qualified by select, so a wipe request is ignored while the part is deselected. A wipe may occur during either a read or a write access. Ordinary access resumes on the first edge after the wipe input or select returns high.

Reads are registered, so data appears on the output one edge after the read is sampled. The output holds its value during writes and while the part is deselected. Whenever a wipe is sampled, the output is driven to zero. The wipe has a minimum duration of a configurable number of edges. A busy flag shows that the current wipe has not yet reached this minimum. A one-cycle flag reports a wipe that ended too early.

Top module: `sram_bulk_zero`

## Requirements
- R1: On an edge with sel_n=0, wipe_n=1, wr_n=0, the word at addr takes din. On an edge with sel_n=0, wipe_n=1, wr_n=1, dout takes the stored word at addr after that edge.
- R2: An edge with sel_n=0 and wipe_n=0 sets every word of the array to zero. Every later read of any address returns 0 until that address is written again.
- R3: wipe_n=0 while sel_n=1 has no effect. Stored contents are kept, dout holds its value, and neither status flag rises.
- R4: A wipe has priority over a write. With sel_n=0, wipe_n=0 and wr_n=0, din is not stored, and the addressed word reads 0 afterwards.
- R5: After every edge that samples a wipe, dout is 0.
- R6: addr and din are ignored during a wipe. An access on the first edge after the wipe is released takes effect with no gap.
- R7: wipe_busy is 1 after the 1st through (MIN_WIPE-1)th consecutive wipe edges, and 0 at all other times.
- R8: wipe_short is a one-cycle pulse on the edge that ends a wipe held for fewer than MIN_WIPE edges. It stays 0 when a wipe reaches MIN_WIPE edges.
- R9: After a synchronous reset, dout=0, wipe_busy=0, wipe_short=0, and every address reads 0.
- R10: dout keeps its value on write edges and on edges with sel_n=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write strobe |
| wipe_n | input | 1 | Active-low whole-array wipe request |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Registered read data |
| wipe_busy | output | 1 | Wipe not yet held for MIN_WIPE edges |
| wipe_short | output | 1 | Pulse: the last wipe ended too early |

## Verification
The assertions take for granted that every control input is a known 0 or 1 on each sampled edge. They also assume that reset is held on the first edges, so that the history they consult starts from a defined state. The stimulus changes inputs only on falling edges and drives every input to a defined value from the start. The stimulus keeps each wipe to whole cycles. It ends each wipe in two ways: by raising the wipe input and by raising select.

// File: rtl/bz_pkg.sv
package bz_pkg;

    localparam int unsigned ADDR_W_DEF   = 12;
    localparam int unsigned DATA_W_DEF   = 4;
    localparam int unsigned MIN_WIPE_DEF = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_WIPE  = 2'd3
    } bz_op_e;

    // Wipe outranks write; deselect outranks everything.
    function automatic bz_op_e decode_op(logic sel_n, logic wr_n, logic wipe_n);
        if (sel_n)       return OP_IDLE;
        else if (!wipe_n) return OP_WIPE;
        else if (!wr_n)  return OP_WRITE;
        else             return OP_READ;
    endfunction

endpackage

// File: rtl/bz_wipe_timer.sv
module bz_wipe_timer
    import bz_pkg::*;
#(
    parameter int unsigned MIN_WIPE = MIN_WIPE_DEF
) (
    input  logic   clk,
    input  logic   rst,
    input  bz_op_e op,
    output logic   busy,
    output logic   short_pulse
);
    localparam int unsigned CNT_W = (MIN_WIPE < 1) ? 1 : $clog2(MIN_WIPE + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_WIPE);

    logic [CNT_W-1:0] held;
    logic             under_min;

    assign under_min = (held != '0) && (held < LIMIT);
    assign busy      = under_min;

    always_ff @(posedge clk) begin
        if (rst) begin
            held        <= '0;
            short_pulse <= 1'b0;
        end else if (op == OP_WIPE) begin
            if (held < LIMIT) held <= held + 1'b1;
            short_pulse <= 1'b0;
        end else begin
            short_pulse <= under_min;
            held        <= '0;
        end
    end

    AST_BUSY_NEEDS_WIPE: assert property (@(posedge clk) disable iff (rst)
        busy |-> $past(op == OP_WIPE)); // R7

    AST_SHORT_ENDS_WIPE: assert property (@(posedge clk) disable iff (rst)
        short_pulse |-> ($past(op) != OP_WIPE)); // R8

endmodule

// File: rtl/bz_store.sv
module bz_store
    import bz_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  bz_op_e            op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    // Word payloads are never reset; a per-word live bit gates them so
    // the whole array reads zero after one wipe edge.
    logic [DATA_W-1:0] words [DEPTH];
    logic [DEPTH-1:0]  live;

    always_ff @(posedge clk) begin
        if (op == OP_WRITE) words[addr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
            dout <= '0;
        end else begin
            unique case (op)
                OP_WIPE: begin
                    live <= '0;
                    dout <= '0;
                end
                OP_WRITE: live[addr] <= 1'b1;
                OP_READ:  dout <= live[addr] ? words[addr] : '0;
                default: ;
            endcase
        end
    end

    AST_WIPE_KILLS_LIVE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WIPE) |=> (live == '0)); // R2

    AST_WRITE_MARKS_LIVE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_WRITE) |=> live[$past(addr)]); // R1

endmodule

// File: rtl/sram_bulk_zero.sv
module sram_bulk_zero
    import bz_pkg::*;
#(
    parameter int unsigned ADDR_W   = ADDR_W_DEF,
    parameter int unsigned DATA_W   = DATA_W_DEF,
    parameter int unsigned MIN_WIPE = MIN_WIPE_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              wipe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              wipe_busy,
    output logic              wipe_short
);
    bz_op_e op;

    assign op = decode_op(sel_n, wr_n, wipe_n);

    bz_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .addr (addr),
        .din  (din),
        .dout (dout)
    );

    bz_wipe_timer #(
        .MIN_WIPE (MIN_WIPE)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .busy        (wipe_busy),
        .short_pulse (wipe_short)
    );

    AST_WIPE_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !wipe_n) |=> (dout == '0)); // R5

    AST_DESEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> $stable(dout)); // R10

    AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && wipe_n && !wr_n) |=> $stable(dout)); // R10

    AST_DESEL_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> !wipe_busy); // R3

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wipe_busy, wipe_short})); // R8

    AST_SHORT_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        wipe_short |-> $past(wipe_busy)); // R8

endmodule

// File: tb/sim_sram_bulk_zero.sv
module sim_sram_bulk_zero;
    localparam int AW = 12;
    localparam int DW = 4;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_n = 1'b1, wr_n = 1'b1, wipe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic wipe_busy, wipe_short;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    sram_bulk_zero #(.ADDR_W(AW), .DATA_W(DW), .MIN_WIPE(2)) u0 (
        .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .wipe_n(wipe_n),
        .addr(addr), .din(din), .dout(dout),
        .wipe_busy(wipe_busy), .wipe_short(wipe_short)
    );

    function automatic logic [DW-1:0] pat(int a);
        return DW'((a * 5 + (a >> 4) + (a >> 9)) & 15);
    endfunction

    task automatic cyc(logic s, logic w, logic z, int a, logic [DW-1:0] d);
        @(negedge clk);
        sel_n = s; wr_n = w; wipe_n = z; addr = AW'(a); din = d;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(int a, int exp, string req);
        cyc(1'b0, 1'b1, 1'b1, a, '0);
        chk(req, int'(dout), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        // R9 reset state
        chk("R9 dout", int'(dout), 0);
        chk("R9 busy", int'(wipe_busy), 0);
        chk("R9 short", int'(wipe_short), 0);
        rd(5, 0, "R9 read after reset");
        rd(DEPTH - 1, 0, "R9 read top after reset");

        // R1 full write sweep then read-back sweep
        for (int a = 0; a < DEPTH; a++) begin
            cyc(1'b0, 1'b0, 1'b1, a, pat(a));
            if (a == 0 || a == DEPTH - 1) chk("R10 write holds dout", int'(dout), 0);
        end
        for (int a = 0; a < DEPTH; a++) rd(a, int'(pat(a)), "R1 readback");

        // R10 / R3: deselected with wipe low holds dout and keeps contents
        rd(100, int'(pat(100)), "R1 read 100");
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 7, 4'hF);
            chk("R3 dout hold", int'(dout), int'(pat(100)));
            chk("R3 busy low", int'(wipe_busy), 0);
        end
        chk("R3 short low", int'(wipe_short), 0);
        rd(7, int'(pat(7)), "R3 contents kept");
        cyc(1'b0, 1'b0, 1'b1, 8, 4'h3);
        chk("R10 write holds", int'(dout), int'(pat(7)));
        rd(8, 3, "R1 overwrite");

        // R7/R8 short wipe inside a read, ended by wipe_n high
        cyc(1'b0, 1'b1, 1'b0, 8, '0);
        chk("R5 dout zero", int'(dout), 0);
        chk("R7 busy after 1st edge", int'(wipe_busy), 1);
        rd(8, 0, "R2 read after wipe");
        chk("R8 short pulse", int'(wipe_short), 1);
        chk("R7 busy dropped", int'(wipe_busy), 0);
        rd(9, 0, "R2 read after wipe");
        chk("R8 short one cycle", int'(wipe_short), 0);
        for (int a = 0; a < DEPTH; a++) rd(a, 0, "R2 sweep zero");

        // R4/R6 full-length wipe inside a write cycle
        cyc(1'b0, 1'b0, 1'b1, 20, 4'h6);
        rd(20, 6, "R1 write 20");
        cyc(1'b0, 1'b0, 1'b0, 21, 4'hF);
        chk("R7 busy edge1", int'(wipe_busy), 1);
        chk("R5 dout zero", int'(dout), 0);
        cyc(1'b0, 1'b0, 1'b0, 22, 4'hE);
        chk("R7 busy edge2", int'(wipe_busy), 0);
        cyc(1'b0, 1'b0, 1'b0, 23, 4'hD);
        chk("R7 busy edge3", int'(wipe_busy), 0);
        cyc(1'b0, 1'b0, 1'b1, 9, 4'hA);
        chk("R8 no short on full wipe", int'(wipe_short), 0);
        rd(9, 10, "R6 first write after wipe");
        rd(20, 0, "R2 prior word cleared");
        rd(21, 0, "R4 blocked write");
        rd(22, 0, "R4 blocked write");
        rd(23, 0, "R6 addr ignored");

        // R8 short wipe ended by deselect
        cyc(1'b0, 1'b1, 1'b0, 9, '0);
        chk("R7 busy", int'(wipe_busy), 1);
        cyc(1'b1, 1'b1, 1'b0, 9, '0);
        chk("R8 short on deselect end", int'(wipe_short), 1);
        chk("R3 busy low deselect", int'(wipe_busy), 0);
        chk("R10 desel holds zero", int'(dout), 0);
        rd(9, 0, "R2 wipe cleared 9");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule